// File: doc/BRIEF.md
# Comma Word Aligner

This block sits on the receive side of a serial link, behind clock recovery and ahead of an 8b/10b decoder. It takes the recovered bit stream one bit per accepted transfer, finds where the 10-bit symbol boundaries lie by spotting the 7-bit comma pattern in either running-disparity polarity, and then cuts the stream into aligned 10-bit words. Each word leaves with a flag that says whether it carries the comma at its aligned position. Downstream lane-deskew logic and the user logic can use that flag.

Bits are assembled least-significant first: the earliest bit of a word lands in bit 0. Every ten accepted bits, a 20-bit window made of the previous ten bits and the current ten bits is scanned at all ten possible offsets. A comma found at a new offset moves the alignment. The word released in that same slot still uses the old offset, and the next word uses the new one. A lock flag and the current offset are available as plain status pins.

The bit input and the word output both use a valid/ready handshake. The input is accepted only when the output register is empty or is being drained in the same cycle (`s_ready = !m_valid || m_ready`). A stalled output therefore holds the serial input off, and no bit is lost or duplicated. While `m_valid` is high and `m_ready` is low, the word and its flag stay frozen.

Top module: `comma_word_aligner`

## Requirements
- R1: After reset, `m_valid` is 0, `lock` is 0, `align_ofs` is 0, `s_ready` is 1, and the internal 20-bit window holds all zeros.
- R2: Every tenth accepted bit (a bit is accepted when `s_valid && s_ready`) produces one word, and `m_valid` is high in the cycle after that tenth bit is accepted.
- R3: A comma exists at offset k when window bits [k+6:k] equal 7'b1111100 or 7'b0000011, with bit k being the earliest received. `m_comma` reports this test at the offset that was used for the word being output.
- R4: The window shifts each accepted bit in at bit 19, so bit 0 is the oldest bit. The output word is window bits [ofs+9:ofs], taken after the tenth bit has been shifted in, so the earliest bit of the word is at bit 0.
- R5: While unlocked, a word slot with a comma at any offset k sets `align_ofs` to k and raises `lock`. The word from that slot still uses the previous offset.
- R6: While locked, a word slot whose lowest comma offset differs from `align_ofs` moves `align_ofs` to that offset and drops `lock`. A comma at the current offset leaves both unchanged.
- R7: When commas appear at several offsets in one slot, the lowest offset wins.
- R8: `s_ready` equals `!m_valid || m_ready`. A bit offered while `s_ready` is low is not consumed and must be offered again.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_comma` hold their values into the next cycle.
- R10: A word slot without any comma, and any cycle without a word slot, leaves `align_ofs` and `lock` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Serial bit offered |
| s_ready | output | 1 | Serial bit can be taken this cycle |
| s_bit | input | 1 | Serial data bit |
| m_valid | output | 1 | Aligned word available |
| m_ready | input | 1 | Consumer takes the word |
| m_data | output | 10 | Aligned word, earliest bit in bit 0 |
| m_comma | output | 1 | Word carries a comma at its aligned offset |
| lock | output | 1 | Alignment established |
| align_ofs | output | 4 | Current word-boundary offset, 0 to 9 |

## Verification
A wrong phase count makes `m_valid` appear after the wrong number of accepted bits, so the error shows in the first word slot. A wrong window order or a wrong offset shows up in the first released `m_data` as a shifted or mirrored word. A mistake in the offset or lock update shows on `align_ofs` and `lock` one cycle after the slot that holds the comma, and it corrupts every later word. An error in the handshake shows at once as an `s_ready` mismatch, or as a frozen word that changes while `m_ready` is low.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  // comma patterns, bit 0 is the earliest received bit
  localparam logic [6:0] COMMA_POS_DEF = 7'b1111100;
  localparam logic [6:0] COMMA_NEG_DEF = 7'b0000011;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } align_state_e;
endpackage

// File: rtl/cwa_bit_window.sv
module cwa_bit_window #(
  parameter int unsigned WORD_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  bit_in,
  output logic [2*WORD_W-1:0]   win_nxt,
  output logic                  tick
);
  localparam int unsigned WIN_W = 2 * WORD_W;
  localparam int unsigned PH_W  = $clog2(WORD_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);

  logic [WIN_W-1:0] win_q;
  logic [PH_W-1:0]  phase_q;

  // newest bit enters at the top, oldest sits at bit 0
  assign win_nxt = {bit_in, win_q[WIN_W-1:1]};
  assign tick    = accept && (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q   <= '0;
      phase_q <= '0;
    end else if (accept) begin
      win_q   <= win_nxt;
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && phase_q != PH_LAST) |=> (phase_q == $past(phase_q) + 1'b1));

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_LAST);

  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(phase_q));
endmodule

// File: rtl/cwa_comma_scan.sv
module cwa_comma_scan #(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] PAT_A = cwa_pkg::COMMA_POS_DEF,
  parameter logic [COMMA_W-1:0] PAT_B = cwa_pkg::COMMA_NEG_DEF
) (
  input  logic [2*WORD_W-1:0]          win,
  output logic [WORD_W-1:0]            hit,
  output logic                         found,
  output logic [$clog2(WORD_W)-1:0]    first_ofs
);
  localparam int unsigned OFS_W = $clog2(WORD_W);

  // one comparator pair per candidate boundary
  for (genvar k = 0; k < WORD_W; k++) begin : g_ofs
    logic [COMMA_W-1:0] slice;
    assign slice  = win[k +: COMMA_W];
    assign hit[k] = (slice == PAT_A) || (slice == PAT_B);
  end

  // lowest offset has priority
  always_comb begin
    found     = 1'b0;
    first_ofs = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found     = 1'b1;
        first_ofs = OFS_W'(k);
      end
    end
  end
endmodule

// File: rtl/cwa_align_ctrl.sv
module cwa_align_ctrl #(
  parameter int unsigned WORD_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        found,
  input  logic [$clog2(WORD_W)-1:0]   first_ofs,
  output logic [$clog2(WORD_W)-1:0]   ofs_q,
  output logic                        lock
);
  import cwa_pkg::*;

  align_state_e st_q;

  assign lock = (st_q == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      ofs_q <= '0;
    end else if (tick && found) begin
      if (st_q == ST_HUNT) begin
        ofs_q <= first_ofs;
        st_q  <= ST_LOCKED;
      end else if (first_ofs != ofs_q) begin
        ofs_q <= first_ofs;
        st_q  <= ST_HUNT;
      end
    end
  end

  p_first_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && tick && found) |=> (lock && ofs_q == $past(first_ofs)));

  p_realign_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && tick && found && first_ofs != ofs_q) |=> (!lock && ofs_q == $past(first_ofs)));

  p_keep_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && tick && found && first_ofs == ofs_q) |=> (lock && $stable(ofs_q)));

  p_no_comma_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && found)) |=> ($stable(ofs_q) && $stable(lock)));
endmodule

// File: rtl/cwa_word_out.sv
module cwa_word_out #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WORD_W-1:0] word_in,
  input  logic              comma_in,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [WORD_W-1:0] m_data,
  output logic              m_comma,
  output logic              room
);
  assign room = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_comma <= 1'b0;
    end else if (tick) begin
      m_valid <= 1'b1;
      m_data  <= word_in;
      m_comma <= comma_in;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_comma)));

  p_slot_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> m_valid);

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> room);
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int unsigned WORD_W  = 10,
  parameter int unsigned COMMA_W = 7,
  parameter logic [COMMA_W-1:0] PAT_A = cwa_pkg::COMMA_POS_DEF,
  parameter logic [COMMA_W-1:0] PAT_B = cwa_pkg::COMMA_NEG_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic                       s_bit,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic [WORD_W-1:0]          m_data,
  output logic                       m_comma,
  output logic                       lock,
  output logic [$clog2(WORD_W)-1:0]  align_ofs
);
  localparam int unsigned WIN_W = 2 * WORD_W;
  localparam int unsigned OFS_W = $clog2(WORD_W);

  logic              accept;
  logic              tick;
  logic [WIN_W-1:0]  win_nxt;
  logic [WORD_W-1:0] hit;
  logic              found;
  logic [OFS_W-1:0]  first_ofs;
  logic [OFS_W-1:0]  ofs_q;
  logic [WORD_W-1:0] word_sel;
  logic              comma_sel;
  logic              room;

  assign s_ready   = room;
  assign accept    = s_valid && room;
  assign align_ofs = ofs_q;

  cwa_bit_window #(.WORD_W(WORD_W)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .bit_in  (s_bit),
    .win_nxt (win_nxt),
    .tick    (tick)
  );

  cwa_comma_scan #(
    .WORD_W  (WORD_W),
    .COMMA_W (COMMA_W),
    .PAT_A   (PAT_A),
    .PAT_B   (PAT_B)
  ) u_scan (
    .win       (win_nxt),
    .hit       (hit),
    .found     (found),
    .first_ofs (first_ofs)
  );

  cwa_align_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .found     (found),
    .first_ofs (first_ofs),
    .ofs_q     (ofs_q),
    .lock      (lock)
  );

  // word of this slot is cut at the offset held before the update
  assign word_sel  = win_nxt[ofs_q +: WORD_W];
  assign comma_sel = hit[ofs_q];

  cwa_word_out #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .word_in  (word_sel),
    .comma_in (comma_sel),
    .m_ready  (m_ready),
    .m_valid  (m_valid),
    .m_data   (m_data),
    .m_comma  (m_comma),
    .room     (room)
  );

  p_ready_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready);

  p_ofs_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    align_ofs < OFS_W'(WORD_W));
endmodule

// File: tb/comma_word_aligner_bench.sv
module comma_word_aligner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_bit = 1'b0;
  logic       m_ready = 1'b0;
  logic       s_ready;
  logic       m_valid;
  logic [9:0] m_data;
  logic       m_comma;
  logic       lock;
  logic [3:0] align_ofs;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic        e_mv, e_mc, e_lock;
  logic [9:0]  e_md;
  int          e_ofs, e_ph;
  logic [19:0] hist;

  // stimulus generator state
  logic [9:0] tx_word;
  int         tx_left, filler;
  int         comma_pct, valid_pct, ready_pct;
  logic       cur_bit;

  // previous sampled outputs for hold check
  logic       p_mv, p_rdy, p_mc;
  logic [9:0] p_md;

  int seed_ret;

  comma_word_aligner u_comma_word_aligner (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_bit(s_bit), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_comma(m_comma), .lock(lock), .align_ofs(align_ofs)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic has_comma(input logic [19:0] h, input int k);
    logic [6:0] s;
    s = h[k +: 7];
    return (s == 7'b1111100) || (s == 7'b0000011);
  endfunction

  function automatic logic next_tx_bit();
    logic b;
    if (filler > 0) begin
      filler--;
      return 1'($urandom);
    end
    if (tx_left == 0) begin
      if (($urandom % 100) < comma_pct)
        tx_word = ($urandom % 2) ? 10'b0101111100 : 10'b1010000011;
      else
        tx_word = 10'($urandom);
      tx_left = 10;
    end
    b = tx_word[0];
    tx_word = {1'b0, tx_word[9:1]};
    tx_left--;
    return b;
  endfunction

  task automatic compare_outputs();
    chk("R2 m_valid", 32'(m_valid), 32'(e_mv));
    if (e_mv) begin
      chk("R4 m_data bit order and offset", 32'(m_data), 32'(e_md));
      chk("R3 m_comma", 32'(m_comma), 32'(e_mc));
    end
    chk("R5 R6 R10 lock", 32'(lock), 32'(e_lock));
    chk("R5 R7 align_ofs lowest offset", 32'(align_ofs), 32'(e_ofs));
    if (p_mv && !p_rdy) begin
      chk("R9 hold valid", 32'(m_valid), 32'd1);
      chk("R9 hold data", 32'(m_data), 32'(p_md));
      chk("R9 hold comma", 32'(m_comma), 32'(p_mc));
    end
  endtask

  task automatic step();
    logic acc;
    logic [19:0] hn;
    int low;
    @(negedge clk);
    compare_outputs();
    p_mv = m_valid; p_md = m_data; p_mc = m_comma;
    s_valid = (($urandom % 100) < valid_pct);
    m_ready = (($urandom % 100) < ready_pct);
    s_bit   = cur_bit;
    p_rdy   = m_ready;
    #1;
    chk("R8 s_ready", 32'(s_ready), 32'(!e_mv || m_ready));
    acc = s_valid && (!e_mv || m_ready);
    if (acc) begin
      hn = {cur_bit, hist[19:1]};
      if (e_ph == 9) begin
        e_mv = 1'b1;
        e_md = hn[e_ofs +: 10];
        e_mc = has_comma(hn, e_ofs);
        low = -1;
        for (int k = 9; k >= 0; k--)
          if (has_comma(hn, k)) low = k;
        if (low >= 0) begin
          if (!e_lock) begin
            e_ofs = low; e_lock = 1'b1;
          end else if (low != e_ofs) begin
            e_ofs = low; e_lock = 1'b0;
          end
        end
        e_ph = 0;
      end else begin
        if (m_ready) e_mv = 1'b0;
        e_ph++;
      end
      hist = hn;
      cur_bit = next_tx_bit();
    end else if (m_ready) begin
      e_mv = 1'b0;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    seed_ret = $urandom(32'd2024);
    e_mv = 0; e_mc = 0; e_md = '0; e_lock = 0; e_ofs = 0; e_ph = 0; hist = '0;
    tx_left = 0; tx_word = '0; filler = 3;
    comma_pct = 30; valid_pct = 90; ready_pct = 90;
    p_mv = 0; p_rdy = 1; p_md = '0; p_mc = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 reset m_valid", 32'(m_valid), 32'd0);
    chk("R1 reset lock", 32'(lock), 32'd0);
    chk("R1 reset align_ofs", 32'(align_ofs), 32'd0);
    chk("R1 reset s_ready", 32'(s_ready), 32'd1);
    cur_bit = next_tx_bit();
    // initial lock at an odd offset
    run(600);
    // slip the stream by 4 bits, forcing realignment
    filler = 4;
    run(600);
    // heavy back-pressure
    ready_pct = 20;
    run(600);
    // sparse input, no inserted commas
    ready_pct = 90; valid_pct = 50; comma_pct = 0;
    run(400);
    // slip by 7 with dense commas
    valid_pct = 95; comma_pct = 50; filler = 7;
    run(600);
    // mixed random
    valid_pct = 70; ready_pct = 60; comma_pct = 20; filler = 1;
    run(800);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule